// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Periodic Refresh

This block sits between a simple host request port and a dynamic RAM whose address pins are shared between the row and column halves of the address. For each host access it drives the row half onto the shared pins and pulls the active-low row strobe, then switches the pins to the column half and pulls the active-low column strobe. It samples read data a fixed number of cycles after the row strobe fell. It starts no new access until the full cycle time has run out, which leaves room for the row writeback.

Each row access reads and writes back the whole row, so the block keeps the array alive with one row-strobe-only cycle per row. A timer spaces these cycles evenly over the retention window, and a wrapping row counter supplies the addresses. A pending refresh takes the next free slot ahead of any host request, but it never cuts short an access that has already started. The host sees this only as `req_ready` going low.

Top module: `mxdram_ctrl`

## Requirements
- R1: A flat address splits into a row (upper `ADDR_W/2` bits) and a column (lower `ADDR_W/2` bits). For example, with a 4-bit address, location 6 (0110) is row 01, column 10. `dram_addr` carries the row from the cycle the row strobe falls until the column strobe falls, and carries the column while the column strobe is low.
- R2: For an access accepted at clock edge k, `dram_ras_n` is low in the `T_RAS` cycles that follow edge k. It then stays high until the cycle count since it fell reaches `T_RC`, so consecutive falls are at least `T_RC + 1` cycles apart.
- R3: For host accesses, `dram_cas_n` falls `T_RCD` cycles after `dram_ras_n` falls and rises together with it. It is never low while `dram_ras_n` is high.
- R4: For a read, `dram_dq_in` is sampled at the clock edge ending the cycle that lies `T_RAC` cycles after the row strobe fell. `rd_valid` is then high for exactly one cycle with the sampled value on `rd_data`.
- R5: For a write, `dram_we_n` is low and `dram_dq_oe` is high exactly while `dram_cas_n` is low, and `dram_dq_out` carries the accepted write data. For reads and refreshes, `dram_we_n` stays high and `dram_dq_oe` stays low.
- R6: `req_ready` is high only when no access is running and no refresh is pending. A request is taken at an edge where `req_valid` and `req_ready` are both high, and `dram_ras_n` falls in the next cycle.
- R7: A refresh becomes pending every `REF_INT` cycles after reset. A refresh cycle drives only the row strobe, with the row counter's value on `dram_addr`, while the column and write strobes stay high. The row counter starts at 0 and wraps modulo the row count.
- R8: When a refresh is pending and the sequencer is idle, the refresh starts before any waiting host request. A refresh that becomes pending during an access waits until that access has ended.
- R9: Every row sees a row strobe at least once in every `ROWS*REF_INT + T_RC + 5` cycles, so stored data survives an idle period longer than the retention window.
- R10: While `rst` is high, all strobes are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high. The refresh timer restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Flat location address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request is taken at this edge if valid |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | ADDR_W/2 | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq_out | output | DATA_W | Data toward memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data from memory |

## Verification
The refresh timer can expire in the same cycle that a host request is waiting or an access is running. The bench provokes this by holding long back-to-back request streams across many timer periods. A cycle-accurate model in the bench decides each time whether the refresh or the host goes first, and which row is on the pins, and it is compared with the strobes, `dram_addr` and `req_ready` on every clock. A behavioural memory that turns rows to unknown once they exceed their retention count then shows whether data written before a long idle stretch still reads back.

// File: rtl/mxd_pkg.sv
package mxd_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_REFR  = 2'd2
    } mxd_op_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic dq_oe;
    } mxd_strobe_t;

    function automatic logic in_window(input int unsigned pos,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (pos >= lo) && (pos < hi);
    endfunction

endpackage

// File: rtl/mxd_refresh_sched.sv
module mxd_refresh_sched #(
    parameter int ROW_W   = 4,
    parameter int REF_INT = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    output logic             pend,
    output logic [ROW_W-1:0] ref_row
);
    localparam int TMR_W = (REF_INT > 1) ? $clog2(REF_INT) : 1;

    logic [TMR_W-1:0] tmr;
    logic             tick;

    assign tick = (tmr == TMR_W'(REF_INT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr     <= '0;
            pend    <= 1'b0;
            ref_row <= '0;
        end else begin
            tmr  <= tick ? '0 : tmr + 1'b1;
            pend <= tick | (pend & ~take);
            if (take)
                ref_row <= ref_row + 1'b1;
        end
    end

    // A new period must never arrive while the previous refresh is still unserved.
    p_no_lost_refresh_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && !take) |-> !tick);

    p_row_advance_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> (ref_row == $past(ref_row) + 1'b1));

endmodule

// File: rtl/mxd_access_seq.sv
module mxd_access_seq
    import mxd_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8,
    parameter int T_RCD  = 2,
    parameter int T_RAS  = 6,
    parameter int T_RC   = 9,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mxd_op_e           start_op,
    input  logic [ROW_W-1:0]  start_row,
    input  logic [COL_W-1:0]  start_col,
    input  logic [DATA_W-1:0] start_wdata,
    output logic              busy,
    output mxd_op_e           op,
    output logic [CNT_W-1:0]  cnt,
    output mxd_strobe_t       strobes,
    output logic [ROW_W-1:0]  pin_addr,
    output logic [DATA_W-1:0] dq_out
);
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             ras_win;
    logic             cas_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            op     <= OP_READ;
            row_q  <= '0;
            col_q  <= '0;
            dq_out <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                cnt    <= '0;
                op     <= start_op;
                row_q  <= start_row;
                col_q  <= start_col;
                dq_out <= start_wdata;
            end
        end else if (cnt == CNT_W'(T_RC - 1)) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        ras_win = busy && in_window(int'(cnt), 0, T_RAS);
        cas_win = busy && (op != OP_REFR) && in_window(int'(cnt), T_RCD, T_RAS);
        strobes.ras_n = ~ras_win;
        strobes.cas_n = ~cas_win;
        strobes.we_n  = ~(cas_win && op == OP_WRITE);
        strobes.dq_oe = cas_win && op == OP_WRITE;
        pin_addr      = cas_win ? ROW_W'(col_q) : row_q;
    end

    p_cas_under_ras_r3: assert property (@(posedge clk) disable iff (rst)
        !strobes.cas_n |-> !strobes.ras_n);

    p_row_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!strobes.ras_n && !$past(strobes.ras_n) && strobes.cas_n) |-> $stable(pin_addr));

    p_refresh_no_cas_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && op == OP_REFR) |-> (strobes.cas_n && strobes.we_n && !strobes.dq_oe));

endmodule

// File: rtl/mxd_read_capture.sv
module mxd_read_capture
    import mxd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int T_RAC  = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  mxd_op_e           op,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic sample_now;

    assign sample_now = busy && (op == OP_READ) && (cnt == CNT_W'(T_RAC));

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= sample_now;
            if (sample_now)
                rd_data <= dq_in;
        end
    end

    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/mxdram_ctrl.sv
module mxdram_ctrl
    import mxd_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int T_RCD   = 2,
    parameter int T_RAC   = 4,
    parameter int T_RAS   = 6,
    parameter int T_RC    = 9,
    parameter int REF_INT = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W/2-1:0] dram_addr,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic [DATA_W-1:0]   dram_dq_out,
    output logic                dram_dq_oe,
    input  logic [DATA_W-1:0]   dram_dq_in
);
    localparam int COL_W = ADDR_W / 2;
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int CNT_W = $clog2(T_RC + 1);

    logic             busy;
    mxd_op_e          op;
    logic [CNT_W-1:0] cnt;
    mxd_strobe_t      strobes;
    logic             pend;
    logic [ROW_W-1:0] ref_row;
    logic             ref_take;
    logic             host_take;
    mxd_op_e          start_op;
    logic [ROW_W-1:0] start_row;
    logic [ROW_W-1:0] pin_addr;

    always_comb begin
        ref_take  = !busy && pend;
        host_take = !busy && !pend && req_valid;
        req_ready = !busy && !pend;
        if (ref_take) begin
            start_op  = OP_REFR;
            start_row = ref_row;
        end else begin
            start_op  = req_write ? OP_WRITE : OP_READ;
            start_row = req_addr[ADDR_W-1:COL_W];
        end
    end

    mxd_refresh_sched #(
        .ROW_W   (ROW_W),
        .REF_INT (REF_INT)
    ) u_refresh (
        .clk     (clk),
        .rst     (rst),
        .take    (ref_take),
        .pend    (pend),
        .ref_row (ref_row)
    );

    mxd_access_seq #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W),
        .T_RCD  (T_RCD),
        .T_RAS  (T_RAS),
        .T_RC   (T_RC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (ref_take || host_take),
        .start_op    (start_op),
        .start_row   (start_row),
        .start_col   (req_addr[COL_W-1:0]),
        .start_wdata (req_wdata),
        .busy        (busy),
        .op          (op),
        .cnt         (cnt),
        .strobes     (strobes),
        .pin_addr    (pin_addr),
        .dq_out      (dram_dq_out)
    );

    mxd_read_capture #(
        .DATA_W (DATA_W),
        .T_RAC  (T_RAC),
        .CNT_W  (CNT_W)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .op       (op),
        .cnt      (cnt),
        .dq_in    (dram_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign dram_addr  = pin_addr;
    assign dram_ras_n = strobes.ras_n;
    assign dram_cas_n = strobes.cas_n;
    assign dram_we_n  = strobes.we_n;
    assign dram_dq_oe = strobes.dq_oe;

    p_accept_starts_row_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> $fell(dram_ras_n));

    p_ready_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (dram_ras_n && dram_cas_n));

    p_refresh_first_r8: assert property (@(posedge clk) disable iff (rst)
        (pend && !busy) |=> (busy && op == OP_REFR));

endmodule

// File: tb/mxdram_ctrl_bench.sv
`timescale 1ns/1ps
module mxdram_ctrl_bench;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int T_RCD   = 2;
    localparam int T_RAC   = 4;
    localparam int T_RAS   = 6;
    localparam int T_RC    = 9;
    localparam int REF_INT = 40;
    localparam int COLS    = 1 << (ADDR_W / 2);
    localparam int ROWS    = 1 << (ADDR_W - ADDR_W / 2);
    localparam int LOCS    = ROWS * COLS;
    localparam int RETAIN  = ROWS * REF_INT + T_RC + 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [DATA_W-1:0] rd_data, dram_dq_out, dram_dq_in;
    logic [ADDR_W/2-1:0] dram_addr;

    always #2.5 clk = ~clk;

    mxdram_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_RAC(T_RAC),
        .T_RAS(T_RAS), .T_RC(T_RC), .REF_INT(REF_INT)
    ) u_mxdram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            if (n_fail < 40)
                $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // ---------------- behavioural DRAM with decay ----------------
    logic [DATA_W-1:0] mem [LOCS];
    int last_touch [ROWS];
    int max_gap = 0;
    int cyc = 0;
    int lat_row = 0, lat_col = 0;
    logic prev_ras_n = 1'b1, prev_cas_n = 1'b1;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int r = 0; r < ROWS; r++) last_touch[r] = cyc;
        end else begin
            if (prev_ras_n && !dram_ras_n) begin
                lat_row = int'(dram_addr);
                if (cyc - last_touch[lat_row] > max_gap) max_gap = cyc - last_touch[lat_row];
                if (cyc - last_touch[lat_row] > RETAIN)
                    for (int c = 0; c < COLS; c++) mem[lat_row*COLS + c] = 'x;
                last_touch[lat_row] = cyc;
            end
            if (prev_cas_n && !dram_cas_n) begin
                // R3: column strobe must only fall inside a row strobe
                chk("R3", "cas fell with ras high", {31'd0, dram_ras_n}, 32'd0);
                lat_col = int'(dram_addr);
                if (!dram_we_n) mem[lat_row*COLS + lat_col] = dram_dq_out;
            end
        end
        prev_ras_n = dram_ras_n;
        prev_cas_n = dram_cas_n;
    end

    assign dram_dq_in = (!dram_cas_n && dram_we_n) ? mem[lat_row*COLS + lat_col] : 'x;

    // ---------------- cycle reference model ----------------
    logic [DATA_W-1:0] sb [LOCS];
    int m_busy = 0, m_cnt = 0, m_op = 0, m_row = 0, m_col = 0, m_timer = 0;
    int m_pend = 0, m_refrow = 0, m_rdv = 0, m_tick = 0, m_waiting = 0;
    logic [DATA_W-1:0] m_wd = '0, m_rdd = '0, m_rd_next = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_timer = 0; m_pend = 0; m_refrow = 0; m_rdv = 0;
        end else begin
            m_tick = (m_timer == REF_INT - 1);
            m_rdv  = (m_busy != 0 && m_op == 0 && m_cnt == T_RAC);
            if (m_rdv != 0) m_rdd = m_rd_next;
            if (m_busy == 0) begin
                if (m_pend != 0) begin
                    m_busy = 1; m_cnt = 0; m_op = 2; m_row = m_refrow;
                    m_refrow = (m_refrow + 1) % ROWS;
                    m_pend = m_tick;
                end else begin
                    if (req_valid) begin
                        m_busy = 1; m_cnt = 0; m_op = req_write ? 1 : 0;
                        m_row = int'(req_addr) / COLS; m_col = int'(req_addr) % COLS;
                        m_wd = req_wdata;
                        if (req_write) sb[req_addr] = req_wdata;
                        else m_rd_next = sb[req_addr];
                    end
                    m_pend = m_tick;
                end
            end else begin
                if (m_cnt == T_RC - 1) m_busy = 0;
                else m_cnt++;
                if (m_tick != 0) m_pend = 1;
            end
            m_timer = (m_tick != 0) ? 0 : m_timer + 1;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            bit ras_w, cas_w, wr_w;
            ras_w = (m_busy != 0) && (m_cnt < T_RAS);
            cas_w = ras_w && (m_op != 2) && (m_cnt >= T_RCD);
            wr_w  = cas_w && (m_op == 1);
            if (rst) begin
                // R10: idle outputs during reset
                chk("R10", "ras_n", {31'd0, dram_ras_n}, 32'd1);
                chk("R10", "cas_n", {31'd0, dram_cas_n}, 32'd1);
                chk("R10", "dq_oe", {31'd0, dram_dq_oe}, 32'd0);
                chk("R10", "rd_valid", {31'd0, rd_valid}, 32'd0);
                chk("R10", "ready", {31'd0, req_ready}, 32'd1);
            end else begin
                chk("R2", "ras_n", {31'd0, dram_ras_n}, {31'd0, !ras_w});
                chk(m_op == 2 ? "R7" : "R3", "cas_n", {31'd0, dram_cas_n}, {31'd0, !cas_w});
                chk("R5", "we_n", {31'd0, dram_we_n}, {31'd0, !wr_w});
                chk("R5", "dq_oe", {31'd0, dram_dq_oe}, {31'd0, wr_w});
                if (wr_w) chk("R5", "dq_out", {24'd0, dram_dq_out}, {24'd0, m_wd});
                if (ras_w)
                    chk(m_op == 2 ? "R7" : "R1", "addr", {28'd0, dram_addr},
                        cas_w ? m_col : m_row);
                chk((m_pend != 0 && req_valid) ? "R8" : "R6", "ready",
                    {31'd0, req_ready}, {31'd0, (m_busy == 0 && m_pend == 0)});
                chk("R4", "rd_valid", {31'd0, rd_valid}, {31'd0, m_rdv != 0});
                if (m_rdv != 0) chk("R4", "rd_data", {24'd0, rd_data}, {24'd0, m_rdd});
            end
        end
    end

    // ---------------- host driver ----------------
    task automatic host_op(input bit wr, input int addr, input int data);
        bit r;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = ADDR_W'(addr);
        req_wdata = DATA_W'(data);
        forever begin
            r = req_ready;
            @(negedge clk);
            if (r) break;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired R6 actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1/R5: fill every location back to back (refresh collides often, R8)
        for (int a = 0; a < LOCS; a++) host_op(1'b1, a, (a * 7 + 3) & 8'hFF);
        // R4: reads at corner addresses, including location 6 (row 0, column 6)
        host_op(1'b0, 0, 0);
        host_op(1'b0, 6, 0);
        host_op(1'b0, LOCS - 1, 0);
        host_op(1'b0, 8'h5A, 0);
        host_op(1'b0, 8'hA5, 0);
        host_op(1'b1, 8'hA5, 8'h3C);
        host_op(1'b0, 8'hA5, 0);
        // R9: long idle beyond retention, only refresh keeps rows alive
        repeat (3 * RETAIN) @(negedge clk);
        for (int a = 0; a < LOCS; a++) host_op(1'b0, a, 0);
        repeat (T_RC + 4) @(negedge clk);
        // R9: no row went longer than the retention bound without a row strobe
        for (int r = 0; r < ROWS; r++)
            if (cyc - last_touch[r] > max_gap) max_gap = cyc - last_touch[r];
        chk("R9", "max row gap within bound", {31'd0, max_gap > RETAIN}, 32'd0);
        finish_run();
    end

endmodule